// File: doc/BRIEF.md
# Graphics Plane Pixel Format Unpacker

This block sits between a plane's pixel fetch engine and a display mixer. It takes 32-bit memory words on a valid/ready stream and emits one normalised ARGB pixel per output transfer, 8 bits per channel, with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. A plain control word selects the source pixel layout, the byte order, whether alpha sits at the low or the high end of a pixel, and how an 8-bit alpha is scaled.

Pixels of 16 bits are unpacked two to a word. Pixels of 24 bits are packed across word boundaries, so three words carry four pixels; the block keeps the leftover bytes of a word and a lane position for this. Channels narrower than 8 bits are widened by repeating their top bits. A control word can be staged so that it only takes effect on the next frame-sync pulse. Any change of the active settings, and every frame-sync pulse, restarts the lane position at the first pixel of a word.

Back-pressure rules: an input word is taken only in a cycle where `in_valid` and `in_ready` are both high, and the source must hold `in_data` steady until then. A word holding two pixels keeps `in_ready` low while its first pixel is emitted. The output register is loaded whenever it is empty or being drained; while `out_valid` is high and `out_ready` is low, the pixel is held unchanged and no input is taken. A frame-sync pulse in the middle of a 16-bit or 24-bit word restarts that word from its first pixel.

Top module: `pixel_unpack`

## Requirements
- R1: The format code is `cfg_word[4:0]`. Code 0x05 is ARGB8888 (alpha in bits 31:24, then red, green, blue) and code 0x02 is 32-bit RGB with bits 31:24 ignored; each 32-bit format yields one pixel per word.
- R2: Codes 0x00 (RGB565: red 15:11, green 10:5, blue 4:0), 0x06 (ARGB1555: alpha bit 15, red 14:10, green 9:5, blue 4:0) and 0x07 (ARGB4444: alpha 15:12, red 11:8, green 7:4, blue 3:0) yield two pixels per word; with `cfg_word[23]` clear the pixel in bits 15:0 comes first, with it set the pixel in bits 31:16 comes first, and `in_ready` stays low while the first of the two is emitted.
- R3: Codes 0x01 (RGB888: red 23:16, green 15:8, blue 7:0) and 0x04 (ARGB8565: alpha 23:16, red 15:11, green 10:5, blue 4:0) are 24-bit pixels packed byte after byte starting at bit 0 of the first word: three words give four pixels, the second and third pixels straddling word boundaries.
- R4: With `cfg_word[23]` set, a 32-bit pixel has its four bytes reversed and a 24-bit pixel its three bytes reversed before fields are taken.
- R5: With `cfg_word[6]` set, alpha occupies the low end of the pixel and the colour fields move up by the alpha width in the same red, green, blue order; for 0x02 the ignored byte moves to bits 7:0; for 0x00 and 0x01 the bit has no effect. Code 0x05 with bits 23 and 6 set reads ABGR memory order; code 0x02 with both set reads XBGR.
- R6: A 5-bit field v widens to {v, v[4:2]}, a 6-bit field to {v, v[5:4]}, a 4-bit field to {v, v}, and the 1-bit alpha to 0x00 or 0xFF.
- R7: Codes 0x00, 0x01 and 0x02 produce alpha 0xFF.
- R8: For codes 0x04 and 0x05, with `cfg_word[5]` set the 8-bit alpha passes unchanged; with it clear an alpha of 128 or more becomes 0xFF and an alpha a below 128 becomes 2a.
- R9: Codes 0x03 and 0x08 to 0x1F yield one pixel per word with value 0x00000000 and set `fmt_error`, which stays set until reset.
- R10: A pixel is visible on `out_argb` with `out_valid` high one clock after the cycle that produced it; while `out_valid` is high and `out_ready` low, the pixel holds and `in_ready` is low.
- R11: With `cfg_word[31]` clear, a new control word becomes active one clock later; with it set, the active settings are unchanged until a cycle with `frame_sync` high, and a pixel produced in that cycle still uses the old settings.
- R12: After reset `out_valid` and `fmt_error` are low and the active settings are all zero (RGB565, little-endian order).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Control word: code 4:0, alpha range 5, swap 6, byte order 23, hold until sync 31 |
| frame_sync | input | 1 | One-cycle frame-sync pulse |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word taken this cycle when high with in_valid |
| in_data | input | 32 | Fetched memory word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Mixer accepts the pixel |
| out_argb | output | 32 | Pixel, alpha 31:24, red 23:16, green 15:8, blue 7:0 |
| fmt_error | output | 1 | Sticky unsupported-format flag |

## Verification
The two functions that share a cycle are the release of staged settings by a frame-sync pulse and a word handoff on the input stream. The bench stages an ABGR setting with the hold bit, then raises `frame_sync` in exactly the cycle a 32-bit word is taken; the pixel of that cycle must still be decoded as ARGB8888 while the next identical word must come out with red and blue exchanged and alpha taken from the low byte. A second coincidence, output stall with a new word waiting, is provoked by dropping `out_ready` and judged by the held pixel and a low `in_ready`.

// File: rtl/pxu_pkg.sv
`timescale 1ns/100ps
package pxu_pkg;
  localparam int WORD_W  = 32;
  localparam int PIX_W   = 32;
  localparam int CODE_W  = 5;
  localparam int NBYTES  = WORD_W / 8;
  localparam int CARRY_W = 16;

  localparam int BIT_FULLA = 5;
  localparam int BIT_SWAP  = 6;
  localparam int BIT_BE    = 23;
  localparam int BIT_HOLD  = 31;

  localparam logic [CODE_W-1:0] C_RGB565   = 5'h00;
  localparam logic [CODE_W-1:0] C_RGB888   = 5'h01;
  localparam logic [CODE_W-1:0] C_XRGB32   = 5'h02;
  localparam logic [CODE_W-1:0] C_ARGB8565 = 5'h04;
  localparam logic [CODE_W-1:0] C_ARGB8888 = 5'h05;
  localparam logic [CODE_W-1:0] C_ARGB1555 = 5'h06;
  localparam logic [CODE_W-1:0] C_ARGB4444 = 5'h07;

  typedef enum logic [1:0] {PK_16 = 2'd0, PK_24 = 2'd1, PK_32 = 2'd2} pack_e;

  typedef struct packed {
    logic              be;
    logic              swap;
    logic              full_a;
    logic [CODE_W-1:0] code;
  } cfg_t;

  function automatic pack_e pack_of(input logic [CODE_W-1:0] c);
    case (c)
      C_RGB565, C_ARGB1555, C_ARGB4444: return PK_16;
      C_RGB888, C_ARGB8565:             return PK_24;
      default:                          return PK_32;
    endcase
  endfunction

  function automatic logic [7:0] wid5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] wid6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] wid4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] alpha8(input logic [7:0] a, input logic full);
    if (full)      return a;
    else if (a[7]) return 8'hFF;
    else           return {a[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/pxu_cfg_shadow.sv
`timescale 1ns/100ps
module pxu_cfg_shadow
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_in,
  input  logic              frame_sync,
  output cfg_t              act,
  output logic              restart
);
  cfg_t inc;
  logic load;
  logic cfg_unused;

  assign inc.be     = cfg_in[BIT_BE];
  assign inc.swap   = cfg_in[BIT_SWAP];
  assign inc.full_a = cfg_in[BIT_FULLA];
  assign inc.code   = cfg_in[CODE_W-1:0];
  assign cfg_unused = ^{cfg_in[30:24], cfg_in[22:7]};

  always_comb begin
    load    = !cfg_in[BIT_HOLD] || frame_sync;
    restart = frame_sync || (load && (inc != act));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    act <= '0;
    else if (load) act <= inc;
  end

  // R11: staged settings wait for the sync pulse
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_in[BIT_HOLD] && !frame_sync) |=> $stable(act));
  // R11: the sync pulse applies the settings seen in its cycle
  p_apply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (act == $past(inc)));
endmodule

// File: rtl/pxu_lane.sv
`timescale 1ns/100ps
module pxu_lane
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              fire,
  input  pack_e             pack,
  input  logic              be,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] raw,
  output logic              last
);
  logic               sub;
  logic [1:0]         phase;
  logic [CARRY_W-1:0] carry;
  logic [23:0]        p24_sel, p24;
  logic [15:0]        h16;
  logic [WORD_W-1:0]  w_rev;

  for (genvar k = 0; k < NBYTES; k++) begin : g_rev
    assign w_rev[8*k +: 8] = word[8*(NBYTES-1-k) +: 8];
  end

  always_comb begin
    case (phase)
      2'd0:    p24_sel = word[23:0];
      2'd1:    p24_sel = {word[15:0], carry[7:0]};
      default: p24_sel = sub ? word[31:8] : {word[7:0], carry};
    endcase
    p24 = be ? {p24_sel[7:0], p24_sel[15:8], p24_sel[23:16]} : p24_sel;
    h16 = (sub ^ be) ? word[31:16] : word[15:0];
    case (pack)
      PK_16: begin raw = {16'h0, h16}; last = sub; end
      PK_24: begin raw = {8'h0, p24};  last = (phase != 2'd2) || sub; end
      default: begin raw = be ? w_rev : word; last = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sub   <= 1'b0;
      phase <= 2'd0;
      carry <= '0;
    end else if (fire) begin
      case (pack)
        PK_16: sub <= !sub;
        PK_24: begin
          case (phase)
            2'd0: begin carry[7:0] <= word[31:24]; phase <= 2'd1; end
            2'd1: begin carry <= word[31:16];      phase <= 2'd2; end
            default: begin
              if (sub) begin sub <= 1'b0; phase <= 2'd0; end
              else sub <= 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  // R3: lane phase never leaves the three-word cycle
  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  // R3: the first word of a group hands over to the second
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart && pack == PK_24 && phase == 2'd0) |=> (phase == 2'd1));
  // R2: first half of a 16-bit word is followed by the second half
  p_half_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart && pack == PK_16 && !sub) |=> sub);
endmodule

// File: rtl/pxu_decode.sv
`timescale 1ns/100ps
module pxu_decode
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  cfg_t              cfg,
  output logic [PIX_W-1:0]  argb,
  output logic              bad
);
  logic [7:0] a, r, g, b;

  always_comb begin
    bad = 1'b0;
    a = 8'hFF; r = '0; g = '0; b = '0;
    case (cfg.code)
      C_RGB565: begin
        r = wid5(raw[15:11]); g = wid6(raw[10:5]); b = wid5(raw[4:0]);
      end
      C_ARGB1555: begin
        if (cfg.swap) begin
          r = wid5(raw[15:11]); g = wid5(raw[10:6]); b = wid5(raw[5:1]);
          a = {8{raw[0]}};
        end else begin
          a = {8{raw[15]}};
          r = wid5(raw[14:10]); g = wid5(raw[9:5]); b = wid5(raw[4:0]);
        end
      end
      C_ARGB4444: begin
        if (cfg.swap) begin
          r = wid4(raw[15:12]); g = wid4(raw[11:8]); b = wid4(raw[7:4]);
          a = wid4(raw[3:0]);
        end else begin
          a = wid4(raw[15:12]);
          r = wid4(raw[11:8]); g = wid4(raw[7:4]); b = wid4(raw[3:0]);
        end
      end
      C_RGB888: begin
        r = raw[23:16]; g = raw[15:8]; b = raw[7:0];
      end
      C_ARGB8565: begin
        if (cfg.swap) begin
          r = wid5(raw[23:19]); g = wid6(raw[18:13]); b = wid5(raw[12:8]);
          a = alpha8(raw[7:0], cfg.full_a);
        end else begin
          a = alpha8(raw[23:16], cfg.full_a);
          r = wid5(raw[15:11]); g = wid6(raw[10:5]); b = wid5(raw[4:0]);
        end
      end
      C_XRGB32: begin
        if (cfg.swap) begin r = raw[31:24]; g = raw[23:16]; b = raw[15:8]; end
        else          begin r = raw[23:16]; g = raw[15:8];  b = raw[7:0];  end
      end
      C_ARGB8888: begin
        if (cfg.swap) begin
          r = raw[31:24]; g = raw[23:16]; b = raw[15:8];
          a = alpha8(raw[7:0], cfg.full_a);
        end else begin
          a = alpha8(raw[31:24], cfg.full_a);
          r = raw[23:16]; g = raw[15:8]; b = raw[7:0];
        end
      end
      default: begin
        bad = 1'b1;
        a   = 8'h00;
      end
    endcase
    argb = {a, r, g, b};
  end
endmodule

// File: rtl/pixel_unpack.sv
`timescale 1ns/100ps
module pixel_unpack
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              frame_sync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_argb,
  output logic              fmt_error
);
  cfg_t              act;
  logic              restart;
  pack_e             pack;
  logic              can_load, fire, last, bad;
  logic [WORD_W-1:0] raw;
  logic [PIX_W-1:0]  pix;

  pxu_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_word), .frame_sync(frame_sync),
    .act(act), .restart(restart)
  );

  assign pack     = pack_of(act.code);
  assign can_load = !out_valid || out_ready;
  assign fire     = in_valid && can_load;
  assign in_ready = can_load && last;

  pxu_lane u_lane (
    .clk(clk), .rst_n(rst_n), .restart(restart), .fire(fire),
    .pack(pack), .be(act.be), .word(in_data), .raw(raw), .last(last)
  );

  pxu_decode u_dec (
    .raw(raw), .cfg(act), .argb(pix), .bad(bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_argb  <= '0;
      fmt_error <= 1'b0;
    end else begin
      if (can_load) begin
        out_valid <= fire;
        if (fire) out_argb <= pix;
      end
      if (fire && bad) fmt_error <= 1'b1;
    end
  end

  // R10: a stalled pixel is held
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_argb)));
  // R10: no input is taken during a stall
  p_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R10: a taken word shows a pixel one clock later
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R9: error flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_error |=> fmt_error);
  // R9: the pixel that raises the flag is transparent black
  p_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $rose(fmt_error)) |-> (out_argb == '0));
endmodule

// File: tb/tb_pixel_unpack.sv
`timescale 1ns/100ps
module tb_pixel_unpack;
  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] cfg;
    logic [31:0] word;
    logic [1:0]  npix;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 32'h00000000, 32'h1234F800, 2'd2, 32'hFFFF0000, 32'hFF1045A5}, // R2 R6 R7 R12
    '{4'd2, 32'h00800000, 32'h1234F800, 2'd2, 32'hFF1045A5, 32'hFFFF0000}, // R2 order flip
    '{4'd6, 32'h00000006, 32'h7C00801F, 2'd2, 32'hFF0000FF, 32'h00FF0000}, // R6 1-bit alpha
    '{4'd6, 32'h00000007, 32'h00008F3C, 2'd2, 32'h88FF33CC, 32'h00000000}, // R6 4-bit
    '{4'd5, 32'h00000047, 32'h0000F3C8, 2'd2, 32'h88FF33CC, 32'h00000000}, // R5 swapped 4444
    '{4'd1, 32'h00000025, 32'h40112233, 2'd1, 32'h40112233, 32'h0},        // R1 R8 full
    '{4'd8, 32'h00000005, 32'h40112233, 2'd1, 32'h80112233, 32'h0},        // R8 reduced
    '{4'd8, 32'h00000005, 32'h80AABBCC, 2'd1, 32'hFFAABBCC, 32'h0},        // R8 at 128
    '{4'd8, 32'h00000005, 32'h7F000000, 2'd1, 32'hFE000000, 32'h0},        // R8 below 128
    '{4'd4, 32'h00800065, 32'h40CCBBAA, 2'd1, 32'h40AABBCC, 32'h0},        // R4 R5 ABGR
    '{4'd7, 32'h00000002, 32'h99123456, 2'd1, 32'hFF123456, 32'h0},        // R7 R1 XRGB
    '{4'd5, 32'h00800042, 32'h99563412, 2'd1, 32'hFF123456, 32'h0},        // R5 XBGR
    '{4'd3, 32'h00000001, 32'h44332211, 2'd1, 32'hFF332211, 32'h0},        // R3 word 0
    '{4'd3, 32'h00000001, 32'h88776655, 2'd1, 32'hFF665544, 32'h0},        // R3 word 1
    '{4'd3, 32'h00000001, 32'hCCBBAA99, 2'd2, 32'hFF998877, 32'hFFCCBBAA}, // R3 word 2
    '{4'd4, 32'h00800001, 32'h44332211, 2'd1, 32'hFF112233, 32'h0},        // R4 24-bit
    '{4'd4, 32'h00800001, 32'h88776655, 2'd1, 32'hFF445566, 32'h0},
    '{4'd4, 32'h00800001, 32'hCCBBAA99, 2'd2, 32'hFF778899, 32'hFFAABBCC},
    '{4'd8, 32'h00000024, 32'h0080F81F, 2'd1, 32'h80FF00FF, 32'h0},        // R8 8565 full
    '{4'd8, 32'h00000004, 32'h0040F81F, 2'd1, 32'h80FF00FF, 32'h0},        // R8 8565 reduced
    '{4'd5, 32'h00000041, 32'h00332211, 2'd1, 32'hFF332211, 32'h0},        // R5 ignored on RGB888
    '{4'd9, 32'h00000003, 32'hFFFFFFFF, 2'd1, 32'h00000000, 32'h0}         // R9 bad code
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        frame_sync;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_argb;
  logic        fmt_error;

  int n_chk = 0;
  int n_err = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [31:0] cur_cfg;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pixel_unpack dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .frame_sync(frame_sync),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_argb(out_argb),
    .fmt_error(fmt_error)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // output monitor, samples late in the low phase of the clock
  always begin
    @(negedge clk);
    #2;
    if (mon_en && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R10 actual=%h expected=none (unexpected pixel)", out_argb);
      end else begin
        chk(tag_q[0], out_argb, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  task automatic set_cfg(input logic [31:0] c);
    @(negedge clk);
    cfg_word = c;
    repeat (2) @(negedge clk);
    cur_cfg = c;
  endtask

  task automatic send(input logic [31:0] w, input bit sync, output bit first_took);
    bit took;
    bit first = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_data = w; frame_sync = sync;
    forever begin
      #1 took = in_ready;
      if (first) first_took = took;
      first = 1'b0;
      @(posedge clk);
      @(negedge clk);
      frame_sync = 1'b0;
      if (took) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic expect_pix(input logic [31:0] p, input string t);
    exp_q.push_back(p);
    tag_q.push_back(t);
  endtask

  task automatic drain();
    for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R10 actual=%0d pending expected=0 pending", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    bit tk;
    rst_n = 1'b0; cfg_word = '0; frame_sync = 1'b0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    cur_cfg = '0;
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R12 fmt_error in reset", {31'b0, fmt_error}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", {31'b0, out_valid}, 32'd0);
    mon_en = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].cfg != cur_cfg) set_cfg(VEC[i].cfg);
      if (VEC[i].req == 4'd9) chk("R9 flag low before bad code", {31'b0, fmt_error}, 32'd0);
      expect_pix(VEC[i].e0, tag_name(VEC[i].req));
      if (VEC[i].npix == 2'd2) expect_pix(VEC[i].e1, tag_name(VEC[i].req));
      send(VEC[i].word, 1'b0, tk);
      drain();
      if (VEC[i].req == 4'd9) chk("R9 flag set after bad code", {31'b0, fmt_error}, 32'd1);
    end

    // R9: flag stays set on a good format
    set_cfg(32'h00000025);
    expect_pix(32'h01020304, "R1");
    send(32'h01020304, 1'b0, tk);
    drain();
    chk("R9 flag sticky", {31'b0, fmt_error}, 32'd1);

    // R10: output stall with a new word waiting
    mon_en = 1'b0;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'h11223344;
    #1 chk("R10 in_ready with empty output", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R10 one-cycle latency valid", {31'b0, out_valid}, 32'd1);
    chk("R10 one-cycle latency data", out_argb, 32'h11223344);
    in_data = 32'h55667788;
    #1 chk("R10 in_ready low during stall", {31'b0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 pixel held in stall", out_argb, 32'h11223344);
    chk("R10 valid held in stall", {31'b0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #1 chk("R10 in_ready on release", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R10 next pixel after release", out_argb, 32'h55667788);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 output empties", {31'b0, out_valid}, 32'd0);

    // R2: a 16-bit word is kept until its second pixel
    set_cfg(32'h00000007);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h00008F3C;
    #1 chk("R2 word kept on first half", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R2 first half pixel", out_argb, 32'h88FF33CC);
    #1 chk("R2 word taken on second half", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R2 second half pixel", out_argb, 32'h00000000);
    in_valid = 1'b0;
    @(negedge clk);
    mon_en = 1'b1;

    // R11: staged settings released by a sync pulse coinciding with a handoff
    set_cfg(32'h00000025);
    set_cfg(32'h80800065);
    expect_pix(32'h40CCBBAA, "R11");
    send(32'h40CCBBAA, 1'b0, tk);
    drain();
    expect_pix(32'h40CCBBAA, "R11");
    send(32'h40CCBBAA, 1'b1, tk);
    chk("R11 word taken in sync cycle", {31'b0, tk}, 32'd1);
    drain();
    expect_pix(32'h40AABBCC, "R11");
    send(32'h40CCBBAA, 1'b0, tk);
    drain();

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule